// File: doc/BRIEF.md
# Audio DAC Soft-Reset and Resynchronization Sequencer

This block sits beside the digital datapath of a multichannel audio DAC. Software starts a reset by clearing a run bit; the block then asserts the internal datapath reset a few sample periods later, and releases it a few sample periods after the bit is set again. Every delay is counted in edges of a one-cycle sample-rate strobe. The system clock runs much faster than the strobe, and each counter advances only on strobe cycles.

A window flag rises one clock after the run bit goes low. It stays high through the whole reset and for a short tail after the release. It reports the reset, and it also opens a window in which an external sync event may restart the sample counter. An accepted sync event produces a one-clock counter-reset pulse and forces the sample data to zero for a number of sample periods. A sync event that arrives during a running zero window starts the window again. The sample data is also zero while the internal reset is held.

Top module: `dac_rst_sync`

## Requirements
- R1: After the asynchronous reset, `flag_o`, `win_o`, `dp_rst_o`, `cnt_rst_o` and `zero_o` are all 0.
- R2: When `run_i` is 0 at a clock edge, `flag_o` and `win_o` are 1 after that edge, unless they are already 1.
- R3: With `run_i` held at 0, `dp_rst_o` rises at the edge where the ASSERT_TICKS-th strobe (default 4) since `flag_o` rose is sampled. Earlier strobes leave it at 0.
- R4: With `dp_rst_o` high and `run_i` back at 1, `dp_rst_o` falls at the edge where the RELEASE_TICKS-th strobe (default 3) since `run_i` returned to 1 is sampled.
- R5: After `dp_rst_o` falls, `flag_o` falls at the edge where the TAIL_TICKS-th strobe (default 2) is sampled, provided `run_i` stays 1.
- R6: If `run_i` returns to 1 before `dp_rst_o` has risen, the pending assertion is cancelled. `dp_rst_o` then stays 0, and `flag_o` falls after TAIL_TICKS strobes. `dp_rst_o` is never 1 while `flag_o` is 0.
- R7: `sync_i` is accepted only while `win_o` is 1, and this includes the period before `dp_rst_o` rises. Outside the window, `sync_i` changes neither `cnt_rst_o` nor `zero_o`.
- R8: An accepted `sync_i` makes `cnt_rst_o` 1 for the next clock and sets `zero_o`. `zero_o` clears at the edge where the ZERO_TICKS-th strobe (default 5) after the event is sampled. A strobe in the same cycle as the event is not counted.
- R9: An accepted `sync_i` during a running zero window restarts the ZERO_TICKS count.
- R10: `smp_o` is 0 while `zero_o` or `dp_rst_o` is 1. Otherwise it equals `smp_i` in the same cycle (default combinational output).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fs_i | input | 1 | One-clock strobe per sample period |
| run_i | input | 1 | Software run bit, 0 requests reset |
| sync_i | input | 1 | External sample-counter sync event |
| smp_i | input | DW | Sample data from the datapath |
| smp_o | output | DW | Sample data after zero forcing |
| dp_rst_o | output | 1 | Delayed internal datapath reset |
| flag_o | output | 1 | Reset/zero-detect flag |
| win_o | output | 1 | Resync enable window |
| cnt_rst_o | output | 1 | Sample-counter reset pulse |
| zero_o | output | 1 | Force-zero control |

## Verification
The assertions check several rules on every cycle:
- the internal reset never appears outside the flag;
- the reset only rises while the run bit is low, and only falls while it is high;
- every rise or fall counted in sample periods lands on a strobe cycle;
- a counter-reset pulse only follows an open window, and the force-zero control only rises together with that pulse.

The exact strobe counts need the bench's scenarios, which compare every output with an independent reference model each cycle. These counts are the lag to assertion, the lag to release, the flag tail and the zero-window length. The same scenarios cover the cancelled assertion, the restart of the zero window, and ignored sync events.

// File: rtl/dac_rst_sync_pkg.sv
package dac_rst_sync_pkg;
   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_ARM  = 3'd1,
      PH_HOLD = 3'd2,
      PH_REL  = 3'd3,
      PH_TAIL = 3'd4
   } phase_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction
endpackage

// File: rtl/dac_rst_phase.sv
module dac_rst_phase
   import dac_rst_sync_pkg::*;
#(
   parameter int ASSERT_TICKS  = 4,
   parameter int RELEASE_TICKS = 3,
   parameter int TAIL_TICKS    = 2,
   localparam int MAXT = max3(ASSERT_TICKS, RELEASE_TICKS, TAIL_TICKS),
   localparam int CW   = $clog2(MAXT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_i,
   input  logic run_i,
   output logic dp_rst_o,
   output logic flag_o
);
   phase_e        ph_q, ph_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      ph_d  = ph_q;
      cnt_d = cnt_q;
      unique case (ph_q)
         PH_IDLE: if (!run_i) begin
            ph_d  = PH_ARM;
            cnt_d = '0;
         end
         PH_ARM: if (run_i) begin
            ph_d  = PH_TAIL;
            cnt_d = '0;
         end else if (fs_i) begin
            if (cnt_q == CW'(ASSERT_TICKS - 1)) ph_d = PH_HOLD;
            else cnt_d = cnt_q + 1'b1;
         end
         PH_HOLD: if (run_i) begin
            ph_d  = PH_REL;
            cnt_d = '0;
         end
         PH_REL: if (!run_i) begin
            ph_d = PH_HOLD;
         end else if (fs_i) begin
            if (cnt_q == CW'(RELEASE_TICKS - 1)) begin
               ph_d  = PH_TAIL;
               cnt_d = '0;
            end else cnt_d = cnt_q + 1'b1;
         end
         PH_TAIL: if (!run_i) begin
            ph_d  = PH_ARM;
            cnt_d = '0;
         end else if (fs_i) begin
            if (cnt_q == CW'(TAIL_TICKS - 1)) ph_d = PH_IDLE;
            else cnt_d = cnt_q + 1'b1;
         end
         default: ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
      end else begin
         ph_q  <= ph_d;
         cnt_q <= cnt_d;
      end
   end

   assign dp_rst_o = (ph_q == PH_HOLD) || (ph_q == PH_REL);
   assign flag_o   = (ph_q != PH_IDLE);

   // R6: the reset is always nested inside the flag
   a_r6_rst_inside_flag: assert property (@(posedge clk) disable iff (!rst_n)
      dp_rst_o |-> flag_o);
   // R3: assertion only while the run bit is low, on a strobe
   a_r3_rise_on_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dp_rst_o) |-> ($past(!run_i) && $past(fs_i)));
   // R4: release only while the run bit is high, on a strobe
   a_r4_fall_on_high: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dp_rst_o) |-> ($past(run_i) && $past(fs_i)));
   // R5: the flag drops on a strobe, with the reset already released
   a_r5_flag_drop: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o) |-> ($past(fs_i) && !$past(dp_rst_o)));
endmodule

// File: rtl/dac_zero_window.sv
module dac_zero_window #(
   parameter int ZERO_TICKS = 5,
   localparam int CW = $clog2(ZERO_TICKS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fs_i,
   input  logic win_i,
   input  logic sync_i,
   output logic cnt_rst_o,
   output logic zero_o
);
   logic [CW-1:0] left_q;
   logic          take;

   assign take = sync_i && win_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q    <= '0;
         cnt_rst_o <= 1'b0;
      end else begin
         cnt_rst_o <= take;
         if (take)                        left_q <= CW'(ZERO_TICKS);
         else if (fs_i && left_q != '0)   left_q <= left_q - 1'b1;
      end
   end

   assign zero_o = (left_q != '0);

   // R7: a counter-reset pulse follows an open window only
   a_r7_pulse_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_rst_o |-> $past(win_i));
   // R8: forcing starts together with the pulse
   a_r8_zero_starts_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(zero_o) |-> cnt_rst_o);
   // R8: forcing ends on a strobe
   a_r8_zero_ends_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(zero_o) |-> $past(fs_i));
endmodule

// File: rtl/dac_data_gate.sv
module dac_data_gate #(
   parameter int DW      = 24,
   parameter bit REG_OUT = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          kill_i,
   input  logic [DW-1:0] smp_i,
   output logic [DW-1:0] smp_o
);
   logic [DW-1:0] gated;

   assign gated = kill_i ? '0 : smp_i;

   generate
      if (REG_OUT) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) smp_o <= '0;
            else        smp_o <= gated;
         end
      end else begin : g_comb
         logic unused_ok;
         assign unused_ok = clk ^ rst_n;
         assign smp_o = gated;
      end
   endgenerate
endmodule

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
   parameter int DW            = 24,
   parameter int ASSERT_TICKS  = 4,
   parameter int RELEASE_TICKS = 3,
   parameter int TAIL_TICKS    = 2,
   parameter int ZERO_TICKS    = 5,
   parameter bit REG_OUT       = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          fs_i,
   input  logic          run_i,
   input  logic          sync_i,
   input  logic [DW-1:0] smp_i,
   output logic [DW-1:0] smp_o,
   output logic          dp_rst_o,
   output logic          flag_o,
   output logic          win_o,
   output logic          cnt_rst_o,
   output logic          zero_o
);
   generate
      if (DW < 1)            begin : g_bad_dw  $error("DW must be at least 1");            end
      if (ASSERT_TICKS < 1)  begin : g_bad_at  $error("ASSERT_TICKS must be at least 1");  end
      if (RELEASE_TICKS < 1) begin : g_bad_rt  $error("RELEASE_TICKS must be at least 1"); end
      if (TAIL_TICKS < 1)    begin : g_bad_tt  $error("TAIL_TICKS must be at least 1");    end
      if (ZERO_TICKS < 1)    begin : g_bad_zt  $error("ZERO_TICKS must be at least 1");    end
   endgenerate

   logic kill;

   dac_rst_phase #(
      .ASSERT_TICKS (ASSERT_TICKS),
      .RELEASE_TICKS(RELEASE_TICKS),
      .TAIL_TICKS   (TAIL_TICKS)
   ) u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .fs_i    (fs_i),
      .run_i   (run_i),
      .dp_rst_o(dp_rst_o),
      .flag_o  (flag_o)
   );

   assign win_o = flag_o;

   dac_zero_window #(
      .ZERO_TICKS(ZERO_TICKS)
   ) u_zero (
      .clk      (clk),
      .rst_n    (rst_n),
      .fs_i     (fs_i),
      .win_i    (win_o),
      .sync_i   (sync_i),
      .cnt_rst_o(cnt_rst_o),
      .zero_o   (zero_o)
   );

   assign kill = zero_o | dp_rst_o;

   dac_data_gate #(
      .DW     (DW),
      .REG_OUT(REG_OUT)
   ) u_gate (
      .clk   (clk),
      .rst_n (rst_n),
      .kill_i(kill),
      .smp_i (smp_i),
      .smp_o (smp_o)
   );
endmodule

// File: tb/dac_rst_sync_test.sv
`timescale 1ns/1ps
module dac_rst_sync_test;
   localparam int DW = 24;
   localparam int AT = 4, RT = 3, TT = 2, ZT = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fs_i = 1'b0, run_i = 1'b1, sync_i = 1'b0;
   logic [DW-1:0] smp_i = '0;
   logic [DW-1:0] smp_o;
   logic          dp_rst_o, flag_o, win_o, cnt_rst_o, zero_o;

   int n_chk = 0, n_bad = 0;
   bit model_on = 1'b0;

   always #5 clk = ~clk;

   dac_rst_sync #(.DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .fs_i(fs_i), .run_i(run_i), .sync_i(sync_i),
      .smp_i(smp_i), .smp_o(smp_o), .dp_rst_o(dp_rst_o), .flag_o(flag_o),
      .win_o(win_o), .cnt_rst_o(cnt_rst_o), .zero_o(zero_o));

   // independent reference model built from the requirements
   int m_ph, m_c, m_left;
   bit m_pulse;

   function automatic bit m_rst(input int ph);
      return (ph == 2) || (ph == 3);
   endfunction

   function automatic logic [DW-1:0] m_data(input int ph, input int left, input logic [DW-1:0] d);
      return (m_rst(ph) || left != 0) ? '0 : d;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_ph <= 0; m_c <= 0; m_left <= 0; m_pulse <= 1'b0;
      end else begin
         m_pulse <= sync_i && (m_ph != 0);
         if (sync_i && m_ph != 0) m_left <= ZT;
         else if (fs_i && m_left > 0) m_left <= m_left - 1;
         case (m_ph)
            0: if (!run_i) begin m_ph <= 1; m_c <= 0; end
            1: if (run_i) begin m_ph <= 4; m_c <= 0; end
               else if (fs_i) begin if (m_c == AT-1) m_ph <= 2; else m_c <= m_c + 1; end
            2: if (run_i) begin m_ph <= 3; m_c <= 0; end
            3: if (!run_i) m_ph <= 2;
               else if (fs_i) begin if (m_c == RT-1) begin m_ph <= 4; m_c <= 0; end else m_c <= m_c + 1; end
            default: if (!run_i) begin m_ph <= 1; m_c <= 0; end
               else if (fs_i) begin if (m_c == TT-1) m_ph <= 0; else m_c <= m_c + 1; end
         endcase
      end
   end

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && model_on) begin
         chk("R2 R5 flag",   DW'(flag_o),    DW'(m_ph != 0));
         chk("R7 window",    DW'(win_o),     DW'(m_ph != 0));
         chk("R3 R4 reset",  DW'(dp_rst_o),  DW'(m_rst(m_ph)));
         chk("R8 pulse",     DW'(cnt_rst_o), DW'(m_pulse));
         chk("R9 zero",      DW'(zero_o),    DW'(m_left != 0));
         chk("R10 data",     smp_o,          m_data(m_ph, m_left, smp_i));
      end
   end

   task automatic step(input bit t, input bit s);
      fs_i = t; sync_i = s;
      @(negedge clk); #1;
      fs_i = 1'b0; sync_i = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         step(1'b1, 1'b0);
         step(1'b0, 1'b0);
      end
   endtask

   initial begin
      #(200000 * 10);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      #1;
      chk("R1 flag", DW'(flag_o), '0);
      chk("R1 rst",  DW'(dp_rst_o), '0);
      chk("R1 zero", DW'(zero_o), '0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 pulse", DW'(cnt_rst_o), '0);
      chk("R1 win",   DW'(win_o), '0);
      model_on = 1'b1;

      // R10 pass-through
      smp_i = 24'h5A5A5A;
      step(1'b0, 1'b0);
      chk("R10 pass", smp_o, 24'h5A5A5A);

      // R7 sync outside window ignored
      step(1'b0, 1'b1);
      chk("R7 ignored pulse", DW'(cnt_rst_o), '0);
      chk("R7 ignored zero",  DW'(zero_o), '0);

      // R2, R3
      run_i = 1'b0;
      step(1'b0, 1'b0);
      chk("R2 flag up", DW'(flag_o), 1);
      ticks(AT - 1);
      chk("R3 not yet", DW'(dp_rst_o), 0);
      ticks(1);
      chk("R3 asserted", DW'(dp_rst_o), 1);
      chk("R10 zero in reset", smp_o, '0);

      // R8, R9
      step(1'b0, 1'b1);
      chk("R8 pulse", DW'(cnt_rst_o), 1);
      step(1'b0, 1'b0);
      chk("R8 pulse single", DW'(cnt_rst_o), 0);
      ticks(ZT - 1);
      chk("R8 still zero", DW'(zero_o), 1);
      ticks(1);
      chk("R8 zero ends", DW'(zero_o), 0);
      step(1'b0, 1'b1);
      ticks(3);
      step(1'b0, 1'b1);
      ticks(ZT - 1);
      chk("R9 restarted", DW'(zero_o), 1);
      ticks(1);
      chk("R9 ends", DW'(zero_o), 0);

      // R4, R5
      run_i = 1'b1;
      step(1'b0, 1'b0);
      ticks(RT - 1);
      chk("R4 held", DW'(dp_rst_o), 1);
      ticks(1);
      chk("R4 released", DW'(dp_rst_o), 0);
      chk("R5 flag tail", DW'(flag_o), 1);
      ticks(TT - 1);
      chk("R5 flag tail", DW'(flag_o), 1);
      ticks(1);
      chk("R5 flag down", DW'(flag_o), 0);

      // R6 cancel
      run_i = 1'b0;
      step(1'b0, 1'b0);
      ticks(AT - 2);
      run_i = 1'b1;
      step(1'b0, 1'b0);
      chk("R6 cancel rst", DW'(dp_rst_o), 0);
      chk("R6 cancel flag", DW'(flag_o), 1);
      ticks(TT);
      chk("R6 flag down", DW'(flag_o), 0);
      chk("R6 never rst", DW'(dp_rst_o), 0);

      // R7 sync before the reset asserts
      run_i = 1'b0;
      step(1'b0, 1'b0);
      step(1'b0, 1'b1);
      chk("R7 early sync", DW'(cnt_rst_o), 1);
      chk("R7 early rst", DW'(dp_rst_o), 0);
      ticks(AT);
      chk("R3 after early sync", DW'(dp_rst_o), 1);
      run_i = 1'b1;
      ticks(RT + TT + 1);

      // random mix checked against the model
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 39) == 0) run_i = ~run_i;
         smp_i = DW'($urandom);
         step($urandom_range(0, 5) == 0, $urandom_range(0, 24) == 0);
      end

      model_on = 1'b0;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule